// File: doc/BRIEF.md
# Dual-Register Output Macrocell

This block is one output cell of a sum-of-products programmable logic array. The product-term array sits outside it and hands in two groups of already-evaluated product terms, one group per sum term. The cell ORs each group into a sum term, and the two sum terms can be merged on any path. It holds two flip-flops. Each flip-flop has its own clock term, asynchronous clear term and data path. The cell drives one pad through an enable and a programmable inverter. It feeds back each register and the pad level separately.

The clock terms are product terms, so each register captures on a rising edge of its own clock term. That edge is detected on the system clock `clk`. One preset term is shared by the registers and sets a register on its next clock-term edge. A test preload mode writes the pad level into the register picked by a select input. A power-on clear input and the block reset empty both registers. A protection bit, combined with a verify strobe, forces the pad driver off.

Top module: `dual_reg_macrocell`

## Requirements
- R1: Sum term A is the OR of the lowest `SUM_A_TERMS` bits of `pt_a`, and sum term B is the OR of the lowest `SUM_B_TERMS` bits of `pt_b`. Bits above those counts have no effect. The defaults are 6 and 8, and each count may be from 4 to 8.
- R2: Each path has its own merge bit: `cfg_comb_out` for the combinational pin path, `cfg_comb_r1` for register 1 and `cfg_comb_r2` for register 2. When a merge bit is 1, that path uses A OR B. When it is 0, the pin path and register 1 use A, and register 2 uses B.
- R3: A register changes only on a `clk` edge at which its own clock term is 1 and was 0 at the previous `clk` edge. A clock term held high gives no second capture, and one register's clock term never moves the other register.
- R4: While a register's clear term (`ar1_term` or `ar2_term`) is 1, that register reads 0 at once, without waiting for a clock edge. A clock-term edge during that time does not load it. The clear wins over preset and preload.
- R5: `preset_term` = 1 on a clock-term rise outside preload mode loads 1 into that register, whatever its data path holds. A register whose clock term does not rise keeps its value.
- R6: `cfg_src` picks the pad source: 00 selects the combinational sum, 01 selects register 1, and 10 or 11 selects register 2. `pad_o` is that source XOR `cfg_inv`.
- R7: `pad_oe` follows `oe_term`. `fb_q1` and `fb_q2` show the two registers, and `fb_pin` shows `pad_i`, all independently of the pad source.
- R8: With `pl_mode` = 1, a clock-term rise loads `pad_i`, not inverted, into register 1 when `pl_sel` = 0 or into register 2 when `pl_sel` = 1. The register that is not selected holds on its own rise. Preload wins over preset.
- R9: While `por` = 1, both registers read 0 at once, and `pad_o` then equals `cfg_inv` for a register source.
- R10: When `secure` = 1 and `verify` = 1, `pad_oe` is 0 regardless of `oe_term`. Either bit alone has no effect.
- R11: While `rst_n` = 0, and for two `clk` edges after it rises, both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the clock terms |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| por | input | 1 | Power-on clear of both registers |
| pt_a | input | 8 | Product terms for sum term A |
| pt_b | input | 8 | Product terms for sum term B |
| cfg_comb_out | input | 1 | Merge A and B on the combinational pin path |
| cfg_comb_r1 | input | 1 | Merge A and B into register 1 |
| cfg_comb_r2 | input | 1 | Merge A and B into register 2 |
| cfg_src | input | 2 | Pad source select |
| cfg_inv | input | 1 | Pad polarity invert |
| ck1_term | input | 1 | Clock product term of register 1 |
| ck2_term | input | 1 | Clock product term of register 2 |
| ar1_term | input | 1 | Asynchronous clear term of register 1 |
| ar2_term | input | 1 | Asynchronous clear term of register 2 |
| preset_term | input | 1 | Shared synchronous preset term |
| oe_term | input | 1 | Output enable product term |
| pl_mode | input | 1 | Preload test mode |
| pl_sel | input | 1 | Preload target: 0 selects register 1, 1 selects register 2 |
| verify | input | 1 | Verify strobe |
| secure | input | 1 | Protection bit |
| pad_i | input | 1 | Level seen on the pad |
| pad_o | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad drive enable |
| fb_q1 | output | 1 | Register 1 feedback |
| fb_q2 | output | 1 | Register 2 feedback |
| fb_pin | output | 1 | Pad level feedback |

## Verification
The hardest case to reach is a register whose outcome depends on priority. Preset, preload, a merged data path and a clear can all apply on the same clock-term rise, and the result must come from the winner alone. The bench first puts each register into a known value opposite to the outcome under test, by a clear or a preset. It then raises a single clock term for exactly one `clk` edge with the competing terms held, so only the winning term can explain the new value. Holding a clock term high for an extra edge, and raising the other register's term, shows that the edge detection is per register.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  localparam int MAX_PT = 8;
  localparam int MIN_PT = 4;
  localparam int NUM_REG = 2;

  typedef enum logic [1:0] {
    SRC_COMB  = 2'b00,
    SRC_REG1  = 2'b01,
    SRC_REG2  = 2'b10,
    SRC_REG2B = 2'b11
  } pin_src_e;
endpackage

// File: rtl/macrocell_rsync.sv
module macrocell_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/macrocell_sum.sv
module macrocell_sum
  import macrocell_pkg::*;
#(
  parameter int TERMS = 8
) (
  input  logic [MAX_PT-1:0] pt,
  output logic              sum
);
  localparam logic [MAX_PT-1:0] USE_MASK = MAX_PT'((1 << TERMS) - 1);

  always_comb sum = |(pt & USE_MASK);
endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic por,
  input  logic ck_term,
  input  logic ar_term,
  input  logic d,
  input  logic preset,
  input  logic pl_mode,
  input  logic pl_me,
  input  logic pl_data,
  output logic q
);
  logic aclr;
  logic ck_prev;
  logic rise;
  logic q_nxt;

  assign aclr = ar_term | por | ~rst_sync_n;
  assign rise = ck_term & ~ck_prev;

  // clock-term edge detector, cleared only by block reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ck_prev <= 1'b0;
    else             ck_prev <= ck_term;
  end

  // next-state: preload beats preset, preset beats data
  always_comb begin
    q_nxt = q;
    if (pl_mode) begin
      if (pl_me) q_nxt = pl_data;
    end else if (preset) begin
      q_nxt = 1'b1;
    end else begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)      q <= 1'b0;
    else if (rise) q <= q_nxt;
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ar_term || por) |-> !q);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rise && !ar_term && !por) |=> ($stable(q) || ar_term || por));

  assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rise && !pl_mode && preset && !ar_term && !por) |=> (q || ar_term || por));

  assert_preload_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rise && pl_mode && pl_me && !ar_term && !por) |=>
      ((q == $past(pl_data)) || ar_term || por));
endmodule

// File: rtl/dual_reg_macrocell.sv
module dual_reg_macrocell
  import macrocell_pkg::*;
#(
  parameter int SUM_A_TERMS = 6,
  parameter int SUM_B_TERMS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic [MAX_PT-1:0] pt_a,
  input  logic [MAX_PT-1:0] pt_b,
  input  logic              cfg_comb_out,
  input  logic              cfg_comb_r1,
  input  logic              cfg_comb_r2,
  input  logic [1:0]        cfg_src,
  input  logic              cfg_inv,
  input  logic              ck1_term,
  input  logic              ck2_term,
  input  logic              ar1_term,
  input  logic              ar2_term,
  input  logic              preset_term,
  input  logic              oe_term,
  input  logic              pl_mode,
  input  logic              pl_sel,
  input  logic              verify,
  input  logic              secure,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe,
  output logic              fb_q1,
  output logic              fb_q2,
  output logic              fb_pin
);
  logic rst_sync_n;
  logic sum_a, sum_b, sum_ab;
  logic comb_val;
  logic [NUM_REG-1:0] ck_v, ar_v, d_v, q_v;
  logic src_val;
  pin_src_e src_sel;

  macrocell_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  macrocell_sum #(.TERMS(SUM_A_TERMS)) u_sum_a (.pt(pt_a), .sum(sum_a));
  macrocell_sum #(.TERMS(SUM_B_TERMS)) u_sum_b (.pt(pt_b), .sum(sum_b));

  assign sum_ab   = sum_a | sum_b;
  assign comb_val = cfg_comb_out ? sum_ab : sum_a;

  assign ck_v = {ck2_term, ck1_term};
  assign ar_v = {ar2_term, ar1_term};
  assign d_v  = {(cfg_comb_r2 ? sum_ab : sum_b), (cfg_comb_r1 ? sum_ab : sum_a)};

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    macrocell_reg u_reg (
      .clk       (clk),
      .rst_sync_n(rst_sync_n),
      .por       (por),
      .ck_term   (ck_v[g]),
      .ar_term   (ar_v[g]),
      .d         (d_v[g]),
      .preset    (preset_term),
      .pl_mode   (pl_mode),
      .pl_me     (pl_sel == g[0]),
      .pl_data   (pad_i),
      .q         (q_v[g])
    );
  end

  always_comb begin
    src_sel = pin_src_e'(cfg_src);
    unique case (src_sel)
      SRC_COMB: src_val = comb_val;
      SRC_REG1: src_val = q_v[0];
      default:  src_val = q_v[1];
    endcase
  end

  assign pad_o  = src_val ^ cfg_inv;
  assign pad_oe = oe_term & ~(secure & verify);
  assign fb_q1  = q_v[0];
  assign fb_q2  = q_v[1];
  assign fb_pin = pad_i;

  assert_blank_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (secure && verify) |-> !pad_oe);

  assert_por_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    por |-> (!fb_q1 && !fb_q2));
endmodule

// File: tb/test_dual_reg_macrocell.sv
module test_dual_reg_macrocell;
  logic clk = 1'b0;
  logic rst_n, por;
  logic [7:0] pt_a, pt_b;
  logic cfg_comb_out, cfg_comb_r1, cfg_comb_r2, cfg_inv;
  logic [1:0] cfg_src;
  logic ck1_term, ck2_term, ar1_term, ar2_term, preset_term, oe_term;
  logic pl_mode, pl_sel, verify, secure, pad_i;
  logic pad_o, pad_oe, fb_q1, fb_q2, fb_pin;

  int checks = 0;
  int errors = 0;

  always #2.5ns clk = ~clk;

  dual_reg_macrocell i_dual_reg_macrocell (
    .clk(clk), .rst_n(rst_n), .por(por), .pt_a(pt_a), .pt_b(pt_b),
    .cfg_comb_out(cfg_comb_out), .cfg_comb_r1(cfg_comb_r1), .cfg_comb_r2(cfg_comb_r2),
    .cfg_src(cfg_src), .cfg_inv(cfg_inv), .ck1_term(ck1_term), .ck2_term(ck2_term),
    .ar1_term(ar1_term), .ar2_term(ar2_term), .preset_term(preset_term),
    .oe_term(oe_term), .pl_mode(pl_mode), .pl_sel(pl_sel), .verify(verify),
    .secure(secure), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .fb_q1(fb_q1), .fb_q2(fb_q2), .fb_pin(fb_pin)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock-term pulse lasting a single clk edge; returns at the next falling edge
  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 1) ck1_term = 1'b1; else ck2_term = 1'b1;
    @(negedge clk);
    ck1_term = 1'b0; ck2_term = 1'b0;
    #1ns;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; por = 1'b0; pt_a = '0; pt_b = '0;
    cfg_comb_out = 0; cfg_comb_r1 = 0; cfg_comb_r2 = 0; cfg_src = 2'b01; cfg_inv = 0;
    ck1_term = 0; ck2_term = 0; ar1_term = 0; ar2_term = 0; preset_term = 0;
    oe_term = 0; pl_mode = 0; pl_sel = 0; verify = 0; secure = 0; pad_i = 0;
    repeat (3) @(negedge clk);
    // R11: clock edge during reset is ignored
    pt_a = 8'h01; ck1_term = 1'b1;
    @(negedge clk); ck1_term = 1'b0; #1ns;
    check("R11 q1 in reset", fb_q1, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1ns;
    check("R11 q1 after reset", fb_q1, 1'b0);
    check("R11 q2 after reset", fb_q2, 1'b0);
    check("R6 pad from q1", pad_o, 1'b0);
    pt_a = '0;
  endtask

  task automatic t_sum;
    cfg_src = 2'b00; cfg_comb_out = 0;
    pt_a = 8'b1100_0000; #1ns;
    check("R1 terms above count ignored", pad_o, 1'b0);
    pt_a = 8'b0000_0100; #1ns;
    check("R1 term in range", pad_o, 1'b1);
    pt_a = 8'h00; pt_b = 8'h80; #1ns;
    check("R2 separate pin path ignores B", pad_o, 1'b0);
    cfg_comb_out = 1; #1ns;
    check("R2 merged pin path sees B bit 7", pad_o, 1'b1);
    cfg_inv = 1; #1ns;
    check("R6 combinational inverted", pad_o, 1'b0);
    cfg_inv = 0; cfg_comb_out = 0; pt_b = '0;
  endtask

  task automatic t_clock;
    cfg_src = 2'b01;
    @(negedge clk); pt_a = 8'h01;
    pulse(1);
    check("R3 q1 captures", fb_q1, 1'b1);
    check("R3 q2 untouched", fb_q2, 1'b0);
    // hold clock term high: only the first edge counts
    @(negedge clk); ck1_term = 1'b1; pt_a = 8'h01;
    @(negedge clk); pt_a = 8'h00;
    repeat (2) @(negedge clk);
    #1ns;
    check("R3 held clock term no second capture", fb_q1, 1'b1);
    ck1_term = 1'b0;
    // register 2, separate path uses B only
    @(negedge clk); pt_a = 8'h01; pt_b = 8'h00; cfg_comb_r2 = 0;
    pulse(2);
    check("R2 q2 separate ignores A", fb_q2, 1'b0);
    check("R3 q1 unaffected by ck2", fb_q1, 1'b1);
    cfg_comb_r2 = 1;
    pulse(2);
    check("R2 q2 merged takes A", fb_q2, 1'b1);
    cfg_src = 2'b11; #1ns;
    check("R6 src 11 selects q2", pad_o, 1'b1);
    cfg_comb_r2 = 0; pt_a = '0;
  endtask

  task automatic t_aclear;
    @(negedge clk); ar1_term = 1'b1; #1ns;
    check("R4 q1 clears at once", fb_q1, 1'b0);
    pt_a = 8'h01;
    pulse(1);
    check("R4 clock ignored while clearing", fb_q1, 1'b0);
    @(negedge clk); preset_term = 1'b1;
    pulse(1);
    check("R4 clear beats preset", fb_q1, 1'b0);
    @(negedge clk); ar1_term = 1'b0; preset_term = 1'b0; pt_a = '0;
    #1ns;
    check("R4 q2 unaffected by ar1", fb_q2, 1'b1);
  endtask

  task automatic t_preset;
    @(negedge clk); pt_a = '0; pt_b = '0; preset_term = 1'b1;
    @(negedge clk); ar2_term = 1'b1; @(negedge clk); ar2_term = 1'b0;
    pulse(1);
    check("R5 preset sets q1", fb_q1, 1'b1);
    check("R5 q2 without rise keeps 0", fb_q2, 1'b0);
    preset_term = 1'b0;
    cfg_src = 2'b01; cfg_inv = 1; #1ns;
    check("R6 register inverted", pad_o, 1'b0);
    cfg_src = 2'b10; #1ns;
    check("R6 src 10 selects q2", pad_o, 1'b1);
  endtask

  task automatic t_preload;
    // q1 = 1, q2 = 0 here; polarity inverted
    @(negedge clk); pl_mode = 1; pl_sel = 1; pad_i = 1; preset_term = 1;
    pulse(2);
    check("R8 q2 loads pad high regardless of inversion", fb_q2, 1'b1);
    @(negedge clk); pad_i = 0; pl_sel = 0;
    pulse(1);
    check("R8 preload beats preset", fb_q1, 1'b0);
    pulse(2);
    check("R8 unselected q2 holds", fb_q2, 1'b1);
    @(negedge clk); pl_mode = 0; preset_term = 0; cfg_inv = 0;
  endtask

  task automatic t_oe;
    oe_term = 1; pad_i = 1; #1ns;
    check("R7 oe follows term", pad_oe, 1'b1);
    check("R7 pin feedback", fb_pin, 1'b1);
    secure = 1; #1ns;
    check("R10 secure alone", pad_oe, 1'b1);
    verify = 1; #1ns;
    check("R10 secure and verify blank", pad_oe, 1'b0);
    secure = 0; #1ns;
    check("R10 verify alone", pad_oe, 1'b1);
    oe_term = 0; #1ns;
    check("R7 oe term low", pad_oe, 1'b0);
    verify = 0; pad_i = 0; #1ns;
    check("R7 pin feedback low", fb_pin, 1'b0);
  endtask

  task automatic t_por;
    // q2 = 1 from preload test
    @(negedge clk); cfg_src = 2'b10; cfg_inv = 1; por = 1; #1ns;
    check("R9 q2 cleared", fb_q2, 1'b0);
    check("R9 q1 cleared", fb_q1, 1'b0);
    check("R9 pad shows polarity", pad_o, 1'b1);
    @(negedge clk); por = 0;
  endtask

  initial begin
    fork
      begin
        t_reset(); t_sum(); t_clock(); t_aclear();
        t_preset(); t_preload(); t_oe(); t_por();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule